// File: doc/BRIEF.md
# Operand Byte-Lane Realignment Row

This block is one reservation-station row for an 8-bit function unit. It owns a single byte lane of a 32-bit word and holds two operand latches, one for each source. A 32-bit source word can be captured in a row that does not own the byte in question. The word arrives with the byte offset where its element really sits. When that offset does not match the row's own lane, the row sends the word to an external 4x4 byte crossbar permute unit. The row drives one 2-bit select per output byte, chosen so the element byte ends up in the row's lane.

The permuted word comes back on the ordinary forwarding path and overwrites the same latch. A word that already sits in the right lane skips this pass. The row raises its issue request toward the 8-bit ALU only when both latches hold correctly placed data. It then presents the byte from its own lane of each latch. The row keeps at most one permute request in flight and always serves the first source before the second.

Top module: `byte_realign_row`

## Requirements
- R1: After reset both latches are empty, and iss_valid and pm_req_valid are low.
- R2: An arrival whose in_off equals ROW_LANE makes its latch ready at the next clock edge and never produces a permute request.
- R3: An arrival whose in_off differs from ROW_LANE raises pm_req_valid with pm_req_data equal to the captured word. Bits [2i+1:2i] of pm_req_sel give the input byte for output byte i, with value (i - ROW_LANE + in_off) mod 4.
- R4: A pm_rsp_valid pulse writes pm_rsp_data into the latch named by pm_rsp_src (0 = src1, 1 = src2) and makes that latch ready at the next edge.
- R5: At most one permute request is outstanding. pm_req_valid stays low from the edge that accepts a request until the response has been taken.
- R6: When both latches need a permute pass, src1 (in_src = 0, pm_req_src = 0) is requested before src2 (in_src = 1, pm_req_src = 1).
- R7: iss_valid is high only while both latches are ready. iss_a is byte ROW_LANE of the src1 latch and iss_b is byte ROW_LANE of the src2 latch.
- R8: While iss_ready is low, iss_valid and its operands hold. An edge with iss_valid and iss_ready both high empties both latches.
- R9: An arrival aimed at a latch that is not empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand arrival strobe |
| in_src | input | 1 | Target latch: 0 = src1, 1 = src2 |
| in_data | input | 32 | Arriving source word |
| in_off | input | 2 | Byte offset of the element within in_data |
| pm_req_valid | output | 1 | Permute request pending |
| pm_req_ready | input | 1 | Permute unit accepts the request |
| pm_req_src | output | 1 | Latch the request belongs to |
| pm_req_data | output | 32 | Word to be permuted |
| pm_req_sel | output | 8 | Four 2-bit byte selects, one per output byte |
| pm_rsp_valid | input | 1 | Permuted word returning on the forwarding path |
| pm_rsp_src | input | 1 | Latch the returning word belongs to |
| pm_rsp_data | input | 32 | Permuted word |
| iss_valid | output | 1 | Both operands ready for the 8-bit ALU |
| iss_ready | input | 1 | ALU accepts the issue |
| iss_a | output | 8 | Lane byte of src1 |
| iss_b | output | 8 | Lane byte of src2 |

## Verification
Every result of this row is due exactly one clock edge after the stimulus that causes it. An aligned arrival shows as ready, a misaligned one as a pending request, an accepted request drops pm_req_valid, a response marks its latch ready, and an issue handshake empties both latches. The bench drives each input for one full cycle from a falling edge and samples on the next falling edge, so each check reads the state one rising edge later. A bench crossbar model rebuilds the permuted word from the row's own selects, so a wrong select shows up in the issued lane byte as well as in the direct select check.

// File: rtl/realign_pkg.sv
package realign_pkg;

  // Per-latch operand state
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_MISAL = 2'd1,
    SLOT_WAIT  = 2'd2,
    SLOT_READY = 2'd3
  } slot_state_e;

endpackage

// File: rtl/realign_sel.sv
// Builds the crossbar selects that rotate the element byte into the row's lane.
module realign_sel #(
  parameter int LANES    = 4,
  parameter int ROW_LANE = 1,
  localparam int OFF_W   = $clog2(LANES)
) (
  input  logic [OFF_W-1:0]       off,
  output logic [LANES*OFF_W-1:0] sel
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      sel[i*OFF_W +: OFF_W] = OFF_W'((i + LANES - ROW_LANE + int'(off)) % LANES);
    end
  end

endmodule

// File: rtl/operand_slot.sv
// One source operand latch with its alignment state.
module operand_slot
  import realign_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_aligned,
  input  logic [WORD_W-1:0] load_data,
  input  logic [OFF_W-1:0]  load_off,
  input  logic              grant,
  input  logic              rsp_wr,
  input  logic [WORD_W-1:0] rsp_data,
  input  logic              clear,
  output slot_state_e       st_q,
  output logic [WORD_W-1:0] data_q,
  output logic [OFF_W-1:0]  off_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SLOT_EMPTY;
      data_q <= '0;
      off_q  <= '0;
    end else if (clear) begin
      st_q <= SLOT_EMPTY;
    end else begin
      case (st_q)
        SLOT_EMPTY: if (load) begin
          data_q <= load_data;
          off_q  <= load_off;
          st_q   <= load_aligned ? SLOT_READY : SLOT_MISAL;
        end
        SLOT_MISAL: if (grant) st_q <= SLOT_WAIT;
        SLOT_WAIT: if (rsp_wr) begin
          data_q <= rsp_data;
          st_q   <= SLOT_READY;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/byte_realign_row.sv
// Reservation-station row that realigns operand bytes through a permute unit.
module byte_realign_row
  import realign_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int BYTE_W   = 8,
  parameter int ROW_LANE = 1,
  localparam int WORD_W  = LANES * BYTE_W,
  localparam int OFF_W   = $clog2(LANES),
  localparam int SEL_W   = LANES * OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_src,
  input  logic [WORD_W-1:0] in_data,
  input  logic [OFF_W-1:0]  in_off,
  output logic              pm_req_valid,
  input  logic              pm_req_ready,
  output logic              pm_req_src,
  output logic [WORD_W-1:0] pm_req_data,
  output logic [SEL_W-1:0]  pm_req_sel,
  input  logic              pm_rsp_valid,
  input  logic              pm_rsp_src,
  input  logic [WORD_W-1:0] pm_rsp_data,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [BYTE_W-1:0] iss_a,
  output logic [BYTE_W-1:0] iss_b
);

  localparam int NSRC = 2;

  slot_state_e             st     [NSRC];
  logic [WORD_W-1:0]       sdata  [NSRC];
  logic [OFF_W-1:0]        soff   [NSRC];
  logic                    in_aligned;
  logic                    busy;
  logic                    pick0, pick1;
  logic                    req_fire, iss_fire;
  logic [OFF_W-1:0]        pick_off;

  assign in_aligned = (in_off == OFF_W'(ROW_LANE));
  assign busy       = (st[0] == SLOT_WAIT) || (st[1] == SLOT_WAIT);

  // src1 wins the single permute slot
  assign pick0 = (st[0] == SLOT_MISAL);
  assign pick1 = !pick0 && (st[1] == SLOT_MISAL);

  assign pm_req_valid = !busy && (pick0 || pick1);
  assign pm_req_src   = pick1;
  assign pm_req_data  = pick1 ? sdata[1] : sdata[0];
  assign pick_off     = pick1 ? soff[1] : soff[0];
  assign req_fire     = pm_req_valid && pm_req_ready;

  assign iss_valid = (st[0] == SLOT_READY) && (st[1] == SLOT_READY);
  assign iss_fire  = iss_valid && iss_ready;
  assign iss_a     = sdata[0][ROW_LANE*BYTE_W +: BYTE_W];
  assign iss_b     = sdata[1][ROW_LANE*BYTE_W +: BYTE_W];

  realign_sel #(
    .LANES   (LANES),
    .ROW_LANE(ROW_LANE)
  ) u_sel (
    .off(pick_off),
    .sel(pm_req_sel)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_slot
    operand_slot #(
      .WORD_W(WORD_W),
      .OFF_W (OFF_W)
    ) u_slot (
      .clk         (clk),
      .rst         (rst),
      .load        (in_valid && (in_src == 1'(k))),
      .load_aligned(in_aligned),
      .load_data   (in_data),
      .load_off    (in_off),
      .grant       (req_fire && (pm_req_src == 1'(k))),
      .rsp_wr      (pm_rsp_valid && (pm_rsp_src == 1'(k))),
      .rsp_data    (pm_rsp_data),
      .clear       (iss_fire),
      .st_q        (st[k]),
      .data_q      (sdata[k]),
      .off_q       (soff[k])
    );
  end

endmodule

// File: rtl/byte_realign_row_chk.sv
// Protocol checker bound to byte_realign_row.
module byte_realign_row_chk #(
  parameter int ROW_LANE = 1,
  parameter int OFF_W    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_src,
  input logic [OFF_W-1:0] in_off,
  input logic             pm_req_valid,
  input logic             pm_req_ready,
  input logic             pm_req_src,
  input logic             pm_rsp_valid,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [1:0]       st0,
  input logic [1:0]       st1
);

  logic outst;

  always_ff @(posedge clk) begin
    if (rst) outst <= 1'b0;
    else if (pm_req_valid && pm_req_ready) outst <= 1'b1;
    else if (pm_rsp_valid) outst <= 1'b0;
  end

  // R5
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    pm_req_valid |-> !outst);

  // R6
  src1_first_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_req_valid && pm_req_src) |-> (st0 != 2'd1));

  // R7
  issue_ready_chk: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (st0 == 2'd3 && st1 == 2'd3));

  // R8
  issue_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready) |=> (st0 == 2'd0 && st1 == 2'd0));

  // R8
  issue_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |=> iss_valid);

  // R2
  aligned_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_src && st0 == 2'd0 && in_off == OFF_W'(ROW_LANE)) |=> (st0 == 2'd3));

endmodule

bind byte_realign_row byte_realign_row_chk #(
  .ROW_LANE(ROW_LANE),
  .OFF_W   (OFF_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_src      (in_src),
  .in_off      (in_off),
  .pm_req_valid(pm_req_valid),
  .pm_req_ready(pm_req_ready),
  .pm_req_src  (pm_req_src),
  .pm_rsp_valid(pm_rsp_valid),
  .iss_valid   (iss_valid),
  .iss_ready   (iss_ready),
  .st0         (st[0]),
  .st1         (st[1])
);

// File: tb/byte_realign_row_tb.sv
module byte_realign_row_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LANE = 1;

  typedef struct packed {
    logic        bfirst;
    logic [1:0]  aoff;
    logic [31:0] adata;
    logic [1:0]  boff;
    logic [31:0] bdata;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 2'd1, 32'hA1B2C3D4, 2'd1, 32'h11223344},
    '{1'b0, 2'd0, 32'h0F1E2D3C, 2'd1, 32'h55667788},
    '{1'b0, 2'd1, 32'hDEADBEEF, 2'd3, 32'h9ABCDEF0},
    '{1'b0, 2'd2, 32'h13579BDF, 2'd3, 32'h2468ACE0},
    '{1'b1, 2'd3, 32'hCAFEF00D, 2'd0, 32'h76543210},
    '{1'b1, 2'd0, 32'h89ABCDEF, 2'd2, 32'hFEDCBA98}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_src = 1'b0;
  logic [31:0] in_data = '0;
  logic [1:0]  in_off = '0;
  logic        pm_req_valid, pm_req_ready = 1'b0, pm_req_src;
  logic [31:0] pm_req_data;
  logic [7:0]  pm_req_sel;
  logic        pm_rsp_valid = 1'b0, pm_rsp_src = 1'b0;
  logic [31:0] pm_rsp_data = '0;
  logic        iss_valid, iss_ready = 1'b0;
  logic [7:0]  iss_a, iss_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_realign_row #(.ROW_LANE(LANE)) u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_src(in_src), .in_data(in_data), .in_off(in_off),
    .pm_req_valid(pm_req_valid), .pm_req_ready(pm_req_ready), .pm_req_src(pm_req_src),
    .pm_req_data(pm_req_data), .pm_req_sel(pm_req_sel),
    .pm_rsp_valid(pm_rsp_valid), .pm_rsp_src(pm_rsp_src), .pm_rsp_data(pm_rsp_data),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_a(iss_a), .iss_b(iss_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sel(input logic [1:0] off);
    logic [7:0] s;
    for (int i = 0; i < 4; i++) s[i*2 +: 2] = 2'((i + 4 - LANE + int'(off)) % 4);
    return s;
  endfunction

  function automatic logic [31:0] xbar(input logic [31:0] w, input logic [7:0] s);
    logic [31:0] o;
    for (int i = 0; i < 4; i++) o[i*8 +: 8] = w[int'(s[i*2 +: 2])*8 +: 8];
    return o;
  endfunction

  task automatic arrive(input logic src, input logic [1:0] off, input logic [31:0] d);
    in_valid = 1'b1; in_src = src; in_off = off; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Accept the pending request, return the permuted word two cycles later.
  task automatic serve(input logic exp_src, input logic [1:0] off, input logic [31:0] word);
    logic [31:0] d;
    logic [7:0]  s;
    check("R6 request source", {31'b0, pm_req_src}, {31'b0, exp_src});
    check("R3 request data", pm_req_data, word);
    check("R3 request selects", {24'b0, pm_req_sel}, {24'b0, exp_sel(off)});
    d = pm_req_data; s = pm_req_sel;
    pm_req_ready = 1'b1;
    @(negedge clk);
    pm_req_ready = 1'b0;
    check("R5 no second request", {31'b0, pm_req_valid}, 32'd0);
    @(negedge clk);
    check("R5 no second request", {31'b0, pm_req_valid}, 32'd0);
    pm_rsp_valid = 1'b1; pm_rsp_src = pm_req_src_hold(exp_src); pm_rsp_data = xbar(d, s);
    @(negedge clk);
    pm_rsp_valid = 1'b0;
  endtask

  function automatic logic pm_req_src_hold(input logic s);
    return s;
  endfunction

  task automatic fire_issue();
    iss_ready = 1'b1;
    @(negedge clk);
    iss_ready = 1'b0;
    check("R8 emptied after issue", {31'b0, iss_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R7 watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 iss_valid after reset", {31'b0, iss_valid}, 32'd0);
    check("R1 pm_req_valid after reset", {31'b0, pm_req_valid}, 32'd0);

    // Table walk: R2 R3 R4 R6 R7
    for (int v = 0; v < 6; v++) begin
      vec_t t;
      int nreq;
      bit a_done;
      t = VECS[v];
      if (t.bfirst) begin
        arrive(1'b1, t.boff, t.bdata);
        arrive(1'b0, t.aoff, t.adata);
      end else begin
        arrive(1'b0, t.aoff, t.adata);
        arrive(1'b1, t.boff, t.bdata);
      end
      nreq = 0;
      a_done = (t.aoff == 2'(LANE));
      for (int k = 0; k < 4; k++) begin
        if (pm_req_valid) begin
          nreq++;
          if (!a_done) begin
            serve(1'b0, t.aoff, t.adata);
            a_done = 1;
          end else begin
            serve(1'b1, t.boff, t.bdata);
          end
        end
      end
      check("R2 permute pass count", nreq, int'(t.aoff != 2'(LANE)) + int'(t.boff != 2'(LANE)));
      check("R7 iss_valid", {31'b0, iss_valid}, 32'd1);
      check("R7 iss_a lane byte", {24'b0, iss_a}, {24'b0, t.adata[int'(t.aoff)*8 +: 8]});
      check("R4 iss_b lane byte", {24'b0, iss_b}, {24'b0, t.bdata[int'(t.boff)*8 +: 8]});
      fire_issue();
    end

    // R2: aligned arrival ready one edge later with no request
    arrive(1'b0, 2'(LANE), 32'h00AB0000 | 32'h0000_5A00);
    check("R2 no request for aligned", {31'b0, pm_req_valid}, 32'd0);
    check("R7 no issue with one operand", {31'b0, iss_valid}, 32'd0);
    // R9: second arrival to the full src1 latch is ignored
    arrive(1'b0, 2'd3, 32'h77000000);
    check("R9 ignored arrival makes no request", {31'b0, pm_req_valid}, 32'd0);
    arrive(1'b1, 2'(LANE), 32'h0000C300);
    check("R9 original src1 byte kept", {24'b0, iss_a}, 32'h5A);
    // R8: hold while iss_ready low
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 iss_valid held", {31'b0, iss_valid}, 32'd1);
    end
    check("R8 operands held", {16'b0, iss_a, iss_b}, 32'h5AC3);
    fire_issue();

    // R6/R5: both misaligned, src2 arrives first; src1 still goes first
    arrive(1'b1, 2'd0, 32'h4433_2211);
    arrive(1'b0, 2'd2, 32'h8877_6655);
    check("R6 first request is src1", {31'b0, pm_req_src}, 32'd0);
    serve(1'b0, 2'd2, 32'h8877_6655);
    check("R4 src2 requested after src1", {31'b0, pm_req_valid}, 32'd1);
    serve(1'b1, 2'd0, 32'h4433_2211);
    check("R7 issue after both passes", {16'b0, iss_a, iss_b}, 32'h7711);
    fire_issue();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule